// File: doc/BRIEF.md
# Stage-Enabled Multiply-Accumulate Datapath

This block multiplies two unsigned 8-bit operands and adds the product to a running sum. The work is split across three registered stages: a multiplier stage that captures the product, an adder stage that captures the product plus the running sum, and an accumulator stage that commits that sum to the output. None of the stages runs freely. Each stage register loads only in a cycle when its own enable input is high. An external sequencer raises the enables one after another as data moves forward, so a stage that is not in use holds its contents and does not toggle.

One accumulation run takes at most eight products. After the eighth commit the accumulator refuses further loads until the next clear. A one-cycle completion pulse marks the eighth commit. A sticky flag records any carry out of the 18-bit sum.

Top module: `mac_pipe_top`

## Requirements
- R1: In a cycle with `en_mul` high, the product register loads the unsigned product `op_a * op_b`, zero-extended to 17 bits.
- R2: In a cycle with `en_add` high, the sum register loads the product register plus `acc_out`. The low 17 bits are added by a ripple-carry chain and the carry propagates into bit 17. The result wraps modulo 2^18.
- R3: In a cycle with `en_acc` high, while fewer than eight commits have been made in the run, `acc_out` loads the sum register and the commit count increases by one.
- R4: A stage whose enable is low keeps its register unchanged. This holds for the product register, the sum register and the accumulator.
- R5: After eight commits in a run, `en_acc` has no effect. `acc_out` holds its value until `clr`.
- R6: `done` is high for exactly the one cycle that follows the eighth commit of a run, and is low at all other times.
- R7: `ovf` becomes 1 when a sum whose addition carried out of bit 17 is committed. It stays 1 until `clr` or reset.
- R8: `clr` is synchronous and takes priority over `en_add` and `en_acc`. It zeroes `acc_out`, the commit count, the sum register, `done` and `ovf`. It leaves the product register unchanged.
- R9: While `rst_n` is low, all registers are zero, including `acc_out`, `done` and `ovf`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous start-of-run clear |
| en_mul | input | 1 | Load enable for the product register |
| en_add | input | 1 | Load enable for the sum register |
| en_acc | input | 1 | Commit enable for the accumulator |
| op_a | input | 8 | Unsigned multiplicand |
| op_b | input | 8 | Unsigned multiplier |
| acc_out | output | 18 | Accumulated sum |
| done | output | 1 | One-cycle pulse after the eighth commit |
| ovf | output | 1 | Sticky carry-out-of-range flag |

## Verification
The main function is driven by a table of eight operand pairs that includes zero, unity and maximum operands, powers of two and mixed values. Each row has its own expected running sum, so a wrong product bit, a lost carry or a stale operand shows up as a mismatch. Runs of repeated 255 x 255 products cross the 18-bit range on the fifth commit. This separates a correct carry into bit 17 and a correct wrap from a sum that saturates or drops the carry. Directed sequences raise each enable on its own, so a stage that loads when it should hold can be told apart from one that holds correctly. Further sequences commit past the eight-product cap and clear a run while a product is still held in the product register.

// File: rtl/mac_pkg.sv
package mac_pkg;
    localparam int OP_A_W    = 8;
    localparam int OP_B_W    = 8;
    localparam int MULT_W    = OP_A_W + OP_B_W;
    localparam int PROD_W    = MULT_W + 1;
    localparam int ACC_W     = PROD_W + 1;
    localparam int RUN_MAX   = 8;
    localparam int CNT_W     = $clog2(RUN_MAX + 1);
    localparam int HI_W      = ACC_W - PROD_W;

    typedef struct packed {
        logic [ACC_W-1:0] sum;
        logic             sum_ovf;
        logic [ACC_W-1:0] acc;
        logic [CNT_W-1:0] cnt;
        logic             done;
        logic             ovf;
    } acc_state_t;
endpackage

// File: rtl/mac_mul_stage.sv
module mac_mul_stage
    import mac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [OP_A_W-1:0] op_a,
    input  logic [OP_B_W-1:0] op_b,
    output logic [PROD_W-1:0] prod
);
    logic [MULT_W-1:0] mult;
    logic [PROD_W-1:0] prod_d, prod_q;

    always_comb begin
        mult   = {{OP_B_W{1'b0}}, op_a} * {{OP_A_W{1'b0}}, op_b};
        prod_d = prod_q;
        if (en) begin
            prod_d = {{(PROD_W-MULT_W){1'b0}}, mult};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prod_q <= '0;
        end else begin
            prod_q <= prod_d;
        end
    end

    assign prod = prod_q;
endmodule

// File: rtl/mac_ripple_add.sv
module mac_ripple_add #(
    parameter int W = 17
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] s,
    output logic         cout
);
    logic [W:0] c;
    assign c[0] = cin;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign s[i]   = a[i] ^ b[i] ^ c[i];
        assign c[i+1] = (a[i] & b[i]) | (c[i] & (a[i] ^ b[i]));
    end

    assign cout = c[W];
endmodule

// File: rtl/mac_acc_stage.sv
module mac_acc_stage
    import mac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en_add,
    input  logic              en_acc,
    input  logic [PROD_W-1:0] prod,
    output logic [ACC_W-1:0]  acc,
    output logic [CNT_W-1:0]  cnt,
    output logic              done,
    output logic              ovf
);
    acc_state_t st_d, st_q;

    logic [PROD_W-1:0] lo_sum;
    logic              lo_carry;
    logic [HI_W:0]     hi_sum;
    logic              run_full;

    mac_ripple_add #(.W(PROD_W)) u_ripple (
        .a    (st_q.acc[PROD_W-1:0]),
        .b    (prod),
        .cin  (1'b0),
        .s    (lo_sum),
        .cout (lo_carry)
    );

    always_comb begin
        hi_sum   = {1'b0, st_q.acc[ACC_W-1:PROD_W]} + {{HI_W{1'b0}}, lo_carry};
        run_full = (st_q.cnt == CNT_W'(RUN_MAX));

        st_d      = st_q;
        st_d.done = 1'b0;
        if (clr) begin
            st_d = '0;
        end else begin
            if (en_add) begin
                st_d.sum     = {hi_sum[HI_W-1:0], lo_sum};
                st_d.sum_ovf = hi_sum[HI_W];
            end
            if (en_acc && !run_full) begin
                st_d.acc  = st_q.sum;
                st_d.cnt  = st_q.cnt + CNT_W'(1);
                st_d.ovf  = st_q.ovf | st_q.sum_ovf;
                st_d.done = (st_q.cnt == CNT_W'(RUN_MAX - 1));
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc  = st_q.acc;
    assign cnt  = st_q.cnt;
    assign done = st_q.done;
    assign ovf  = st_q.ovf;
endmodule

// File: rtl/mac_pipe_top.sv
module mac_pipe_top
    import mac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en_mul,
    input  logic              en_add,
    input  logic              en_acc,
    input  logic [OP_A_W-1:0] op_a,
    input  logic [OP_B_W-1:0] op_b,
    output logic [ACC_W-1:0]  acc_out,
    output logic              done,
    output logic              ovf
);
    logic [PROD_W-1:0] prod_q;
    logic [CNT_W-1:0]  run_cnt;

    mac_mul_stage u_mul (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en_mul),
        .op_a  (op_a),
        .op_b  (op_b),
        .prod  (prod_q)
    );

    mac_acc_stage u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .en_add (en_add),
        .en_acc (en_acc),
        .prod   (prod_q),
        .acc    (acc_out),
        .cnt    (run_cnt),
        .done   (done),
        .ovf    (ovf)
    );
endmodule

// File: rtl/mac_pipe_chk.sv
module mac_pipe_chk
    import mac_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              clr,
    input logic              en_mul,
    input logic              en_acc,
    input logic [OP_A_W-1:0] op_a,
    input logic [OP_B_W-1:0] op_b,
    input logic [ACC_W-1:0]  acc_out,
    input logic              done,
    input logic              ovf,
    input logic [PROD_W-1:0] prod_q,
    input logic [CNT_W-1:0]  run_cnt
);
    AST_PROD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        en_mul |=> prod_q == PROD_W'({{OP_B_W{1'b0}}, $past(op_a)} * {{OP_A_W{1'b0}}, $past(op_b)})); // R1
    AST_PROD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !en_mul |=> $stable(prod_q)); // R4
    AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_acc && !clr) |=> $stable(acc_out)); // R4
    AST_RUN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cnt == CNT_W'(RUN_MAX) && !clr) |=> $stable(acc_out)); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clr) |=> ovf); // R7
    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc_out == '0 && !ovf && !done && run_cnt == '0)); // R8
endmodule

bind mac_pipe_top mac_pipe_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .en_mul  (en_mul),
    .en_acc  (en_acc),
    .op_a    (op_a),
    .op_b    (op_b),
    .acc_out (acc_out),
    .done    (done),
    .ovf     (ovf),
    .prod_q  (prod_q),
    .run_cnt (run_cnt)
);

// File: tb/mac_pipe_top_test.sv
module mac_pipe_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        en_mul = 1'b0;
    logic        en_add = 1'b0;
    logic        en_acc = 1'b0;
    logic [7:0]  op_a = '0;
    logic [7:0]  op_b = '0;
    logic [17:0] acc_out;
    logic        done;
    logic        ovf;

    int checks = 0;
    int failures = 0;

    // expected model taken from the requirements
    logic [16:0] m_prod = '0;
    logic [17:0] m_sum = '0;
    logic        m_sovf = 1'b0;
    logic [17:0] m_acc = '0;
    int          m_cnt = 0;
    logic        m_ovf = 1'b0;

    localparam logic [15:0] VEC [8] = '{
        16'h0305, 16'h00C8, 16'hFF01, 16'h1010,
        16'h6425, 16'h0101, 16'h8002, 16'h0709
    };

    mac_pipe_top uut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .en_mul(en_mul),
        .en_add(en_add), .en_acc(en_acc), .op_a(op_a), .op_b(op_b),
        .acc_out(acc_out), .done(done), .ovf(ovf)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%0d exp=%0d", req, got, exp);
        end
    endtask

    task automatic do_mul(input logic [7:0] a, input logic [7:0] b);
        @(negedge clk);
        op_a = a; op_b = b; en_mul = 1'b1;
        @(negedge clk);
        en_mul = 1'b0;
        m_prod = 17'(a) * 17'(b);
    endtask

    task automatic do_add();
        logic [18:0] t;
        @(negedge clk);
        en_add = 1'b1;
        @(negedge clk);
        en_add = 1'b0;
        t = 19'(m_acc) + 19'(m_prod);
        m_sum = t[17:0];
        m_sovf = t[18];
    endtask

    task automatic do_acc();
        @(negedge clk);
        en_acc = 1'b1;
        @(negedge clk);
        en_acc = 1'b0;
        if (m_cnt < 8) begin
            m_acc = m_sum;
            m_cnt++;
            m_ovf = m_ovf | m_sovf;
        end
    endtask

    task automatic do_clr();
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        m_acc = '0; m_sum = '0; m_sovf = 1'b0; m_cnt = 0; m_ovf = 1'b0;
    endtask

    initial begin
        #3000000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R9 acc in reset", 32'(acc_out), 0);
        chk("R9 done in reset", 32'(done), 0);
        chk("R9 ovf in reset", 32'(ovf), 0);
        rst_n = 1'b1;

        // R1 R2 R3 R6: table-driven run of eight products
        for (int i = 0; i < 8; i++) begin
            do_mul(VEC[i][15:8], VEC[i][7:0]);
            do_add();
            do_acc();
            chk("R3 running sum", 32'(acc_out), 32'(m_acc));
            chk("R6 done level", 32'(done), (i == 7) ? 1 : 0);
        end
        @(negedge clk);
        chk("R6 done drops", 32'(done), 0);

        // R5: ninth product is refused
        do_mul(8'd50, 8'd50);
        do_add();
        do_acc();
        chk("R5 cap holds acc", 32'(acc_out), 32'(m_acc));
        chk("R5 no second done", 32'(done), 0);

        // R8: clear zeroes the run but keeps the product register
        do_mul(8'd11, 8'd13);
        do_clr();
        chk("R8 acc cleared", 32'(acc_out), 0);
        do_add();
        do_acc();
        chk("R8 product kept", 32'(acc_out), 143);

        // R4: product register holds while en_mul is low
        do_clr();
        do_mul(8'd20, 8'd3);
        @(negedge clk);
        op_a = 8'd99; op_b = 8'd99;
        do_add();
        do_acc();
        chk("R4 product hold", 32'(acc_out), 60);

        // R4: sum register holds while en_add is low
        do_mul(8'd4, 8'd5);
        do_add();
        do_mul(8'd200, 8'd200);
        do_acc();
        chk("R4 sum hold", 32'(acc_out), 80);

        // R4: accumulator holds while en_acc is low
        do_add();
        chk("R4 acc hold", 32'(acc_out), 80);

        // R7 R2: overflow on repeated maximum products
        do_clr();
        for (int i = 0; i < 8; i++) begin
            do_mul(8'd255, 8'd255);
            do_add();
            do_acc();
            if (i == 3) chk("R7 no ovf at 4", 32'(ovf), 0);
            if (i == 4) chk("R7 ovf at 5", 32'(ovf), 1);
        end
        chk("R2 wrapped sum", 32'(acc_out), 258056);
        chk("R7 ovf sticky", 32'(ovf), 1);
        do_clr();
        chk("R8 ovf cleared", 32'(ovf), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule